// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold Interrupts

This block sits between a host register port and a serial shift engine. It buffers outgoing bytes in a transmit queue and incoming bytes in a receive queue, each 64 entries deep. The host pushes bytes into the transmit queue and pops bytes from the receive queue. The shift engine does the opposite on its own strobes. A control word sets one watermark per queue and carries one self-clearing flush bit per queue. A level word reports how many bytes each queue holds.

An interrupt unit turns queue conditions into status flags. There are watermark events, empty and full indications, error flags for overflow and underrun, and two engine events: end of transfer and chip-select release. The host clears status flags by writing ones to them. An enable mask selects which flags drive the single interrupt output. Level-type flags are set again while their condition holds. Error and engine-event flags stay set until the host clears them.

Top module: `fifo_pair_irq`

## Requirements
- R1: During reset and at its release, the control word, level word, status word and mask word read 0, and irq is low.
- R2: Each queue returns bytes in the order they were accepted and holds at most 64 bytes. The level word shows the transmit byte count in bits 23:16 and the receive byte count in bits 7:0.
- R3: A write with cfg_sel=0 loads the transmit watermark from bits 23:16 and the receive watermark from bits 7:0. The control word reads them back in the same positions.
- R4: Writing 1 to control bit 31 flushes only the transmit queue. Writing 1 to control bit 15 flushes only the receive queue. The written bit reads 1 for exactly one cycle and then 0, and the queue is empty from that cycle on.
- R5: Status bit 4 (transmit request) is set while the transmit count is at or below the transmit watermark.
- R6: Status bit 0 (receive ready) is set while the receive count is at or above the receive watermark.
- R7: Status bits follow these conditions: bit 1 receive empty, bit 2 receive full, bit 5 transmit empty, bit 6 transmit full.
- R8: The following accesses are discarded and set a flag that stays set until cleared:
  - a host write to a full transmit queue sets bit 10;
  - an engine pop of an empty transmit queue sets bit 11;
  - an engine push into a full receive queue sets bit 8;
  - a host read of an empty receive queue sets bit 9.
- R9: A pulse on xfer_done sets status bit 12. A pulse on cs_release sets status bit 13. Both flags stay set until cleared.
- R10: A write with cfg_sel=2 clears each status bit whose data bit is 1. A level-type bit cleared while its condition still holds reads 0 for one cycle and then 1 again. An error or event flag stays 0 once cleared.
- R11: A write with cfg_sel=1 loads the enable mask. irq is high exactly when some status bit and its mask bit are both 1.
- R12: A level flag reflects a count change two clock edges after the access that caused it. An error or event flag is set one edge after its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 enable mask, 2 status clear |
| cfg_wdata | input | 32 | Register write data |
| ctl_rd | output | 32 | Control word readback |
| lvl_rd | output | 32 | Queue level word |
| sts_rd | output | 32 | Status word |
| mask_rd | output | 32 | Enable mask readback |
| host_tx_wr | input | 1 | Host pushes a transmit byte |
| host_tx_data | input | 8 | Transmit byte from the host |
| host_rx_rd | input | 1 | Host pops a receive byte |
| host_rx_data | output | 8 | Head of the receive queue |
| eng_tx_pop | input | 1 | Engine pops a transmit byte |
| eng_tx_data | output | 8 | Head of the transmit queue |
| eng_rx_push | input | 1 | Engine pushes a receive byte |
| eng_rx_data | input | 8 | Receive byte from the engine |
| xfer_done | input | 1 | End-of-transfer pulse from the engine |
| cs_release | input | 1 | Chip-select release pulse from the engine |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted read or write pointer shows up at once as a wrong byte at a queue head. The bench catches it on the next pop, because it compares every popped byte with its own queue. A wrong count shows in the level word two edges later at the most. It also shows as a missing or early full, empty or watermark flag. A wrong clear priority shows in the single cycle after a status write, so that cycle is sampled one cycle at a time. Flags that are wrongly sticky, or not sticky, show when the flag is read after the cause has gone.

// File: rtl/fpq_pkg.sv
package fpq_pkg;
  localparam int STS_W    = 14;
  localparam int B_RX_RDY = 0;
  localparam int B_RX_EMP = 1;
  localparam int B_RX_FUL = 2;
  localparam int B_TX_REQ = 4;
  localparam int B_TX_EMP = 5;
  localparam int B_TX_FUL = 6;
  localparam int B_RX_OVF = 8;
  localparam int B_RX_UDR = 9;
  localparam int B_TX_OVF = 10;
  localparam int B_TX_UDR = 11;
  localparam int B_DONE   = 12;
  localparam int B_CSOFF  = 13;
  // flags recomputed from queue levels every cycle
  localparam logic [STS_W-1:0] LEVEL_MASK = 14'h0077;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MASK = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/fpq_fifo.sv
module fpq_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count,
  output logic          over,
  output logic          under
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push && (cnt_q != CW'(DEPTH));
  assign pop_ok  = pop && (cnt_q != '0);
  assign over    = push && !push_ok;
  assign under   = pop && !pop_ok;

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (push_ok) wp_n = bump(wp_q);
      if (pop_ok)  rp_n = bump(rp_q);
      cnt_n = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wp_q] <= push_data;
  end

  assign pop_data = mem[rp_q];
  assign count    = cnt_q;
endmodule

// File: rtl/fpq_ctrl.sv
module fpq_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [7:0]  tx_trig,
  output logic [7:0]  rx_trig,
  output logic        tx_flush,
  output logic        rx_flush,
  output logic [31:0] ctl_word
);
  logic [7:0] tx_trig_q, tx_trig_n, rx_trig_q, rx_trig_n;
  logic       tx_pend_q, tx_pend_n, rx_pend_q, rx_pend_n;

  always_comb begin
    tx_trig_n = tx_trig_q;
    rx_trig_n = rx_trig_q;
    tx_pend_n = 1'b0;
    rx_pend_n = 1'b0;
    if (we) begin
      tx_trig_n = wdata[23:16];
      rx_trig_n = wdata[7:0];
      tx_pend_n = wdata[31];
      rx_pend_n = wdata[15];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_trig_q <= '0;
      rx_trig_q <= '0;
      tx_pend_q <= 1'b0;
      rx_pend_q <= 1'b0;
    end else begin
      tx_trig_q <= tx_trig_n;
      rx_trig_q <= rx_trig_n;
      tx_pend_q <= tx_pend_n;
      rx_pend_q <= rx_pend_n;
    end
  end

  assign tx_trig  = tx_trig_q;
  assign rx_trig  = rx_trig_q;
  assign tx_flush = tx_pend_q;
  assign rx_flush = rx_pend_q;
  assign ctl_word = {tx_pend_q, 7'd0, tx_trig_q, rx_pend_q, 7'd0, rx_trig_q};
endmodule

// File: rtl/fpq_irq.sv
module fpq_irq
  import fpq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-1:0] set_vec,
  input  logic             clr_we,
  input  logic             en_we,
  input  logic [STS_W-1:0] wdata,
  output logic [STS_W-1:0] sts,
  output logic [STS_W-1:0] ena,
  output logic             irq
);
  logic [STS_W-1:0] sts_q, sts_n, ena_q, ena_n, clr;

  assign clr = clr_we ? wdata : '0;

  always_comb begin
    // a clear beats a level condition for one cycle; event flags win over a clear
    sts_n = (sts_q & ~clr) | (set_vec & ~(clr & LEVEL_MASK));
    ena_n = en_we ? wdata : ena_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      ena_q <= '0;
    end else begin
      sts_q <= sts_n;
      ena_q <= ena_n;
    end
  end

  assign sts = sts_q;
  assign ena = ena_q;
  assign irq = |(sts_q & ena_q);
endmodule

// File: rtl/fifo_pair_irq.sv
module fifo_pair_irq
  import fpq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] ctl_rd,
  output logic [31:0] lvl_rd,
  output logic [31:0] sts_rd,
  output logic [31:0] mask_rd,
  input  logic        host_tx_wr,
  input  logic [7:0]  host_tx_data,
  input  logic        host_rx_rd,
  output logic [7:0]  host_rx_data,
  input  logic        eng_tx_pop,
  output logic [7:0]  eng_tx_data,
  input  logic        eng_rx_push,
  input  logic [7:0]  eng_rx_data,
  input  logic        xfer_done,
  input  logic        cs_release,
  output logic        irq
);
  reg_sel_e         sel;
  logic [7:0]       tx_trig, rx_trig;
  logic             tx_flush, rx_flush;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic             tx_over, tx_under, rx_over, rx_under;
  logic [STS_W-1:0] set_vec, sts, ena;

  assign sel = reg_sel_e'(cfg_sel);

  fpq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we && sel == SEL_CTRL),
    .wdata    (cfg_wdata),
    .tx_trig  (tx_trig),
    .rx_trig  (rx_trig),
    .tx_flush (tx_flush),
    .rx_flush (rx_flush),
    .ctl_word (ctl_rd)
  );

  fpq_fifo #(.DEPTH(DEPTH), .DW(8)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_flush),
    .push      (host_tx_wr),
    .push_data (host_tx_data),
    .pop       (eng_tx_pop),
    .pop_data  (eng_tx_data),
    .count     (tx_cnt),
    .over      (tx_over),
    .under     (tx_under)
  );

  fpq_fifo #(.DEPTH(DEPTH), .DW(8)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .push      (eng_rx_push),
    .push_data (eng_rx_data),
    .pop       (host_rx_rd),
    .pop_data  (host_rx_data),
    .count     (rx_cnt),
    .over      (rx_over),
    .under     (rx_under)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[B_RX_RDY] = 8'(rx_cnt) >= rx_trig;
    set_vec[B_RX_EMP] = rx_cnt == '0;
    set_vec[B_RX_FUL] = rx_cnt == CW'(DEPTH);
    set_vec[B_TX_REQ] = 8'(tx_cnt) <= tx_trig;
    set_vec[B_TX_EMP] = tx_cnt == '0;
    set_vec[B_TX_FUL] = tx_cnt == CW'(DEPTH);
    set_vec[B_RX_OVF] = rx_over;
    set_vec[B_RX_UDR] = rx_under;
    set_vec[B_TX_OVF] = tx_over;
    set_vec[B_TX_UDR] = tx_under;
    set_vec[B_DONE]   = xfer_done;
    set_vec[B_CSOFF]  = cs_release;
  end

  fpq_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_we  (cfg_we && sel == SEL_STAT),
    .en_we   (cfg_we && sel == SEL_MASK),
    .wdata   (cfg_wdata[STS_W-1:0]),
    .sts     (sts),
    .ena     (ena),
    .irq     (irq)
  );

  assign lvl_rd  = {8'd0, 8'(tx_cnt), 8'd0, 8'(rx_cnt)};
  assign sts_rd  = {{(32-STS_W){1'b0}}, sts};
  assign mask_rd = {{(32-STS_W){1'b0}}, ena};
endmodule

// File: rtl/fpq_chk.sv
module fpq_chk
  import fpq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [1:0]  cfg_sel,
  input logic [31:0] cfg_wdata,
  input logic [31:0] ctl_rd,
  input logic [31:0] lvl_rd,
  input logic [31:0] sts_rd,
  input logic [31:0] mask_rd,
  input logic        host_tx_wr,
  input logic        host_rx_rd,
  input logic        irq
);
  logic ctl_wr, stat_wr;
  assign ctl_wr  = cfg_we && cfg_sel == 2'd0;
  assign stat_wr = cfg_we && cfg_sel == 2'd2;

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_rd[23:16] <= 8'(DEPTH)) && (lvl_rd[7:0] <= 8'(DEPTH)));

  // R4
  flush_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd[31] && !ctl_wr) |=> !ctl_rd[31]);

  // R4
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd[31] |=> lvl_rd[23:16] == 8'd0);

  // R8
  tx_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_tx_wr && lvl_rd[23:16] == 8'(DEPTH)) |=> sts_rd[B_TX_OVF]);

  // R8
  rx_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rx_rd && lvl_rd[7:0] == 8'd0) |=> sts_rd[B_RX_UDR]);

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd[B_TX_OVF] && !(stat_wr && cfg_wdata[B_TX_OVF])) |=> sts_rd[B_TX_OVF]);

  // R11
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_rd == 32'd0) |-> !irq);
endmodule

bind fifo_pair_irq fpq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_sel    (cfg_sel),
  .cfg_wdata  (cfg_wdata),
  .ctl_rd     (ctl_rd),
  .lvl_rd     (lvl_rd),
  .sts_rd     (sts_rd),
  .mask_rd    (mask_rd),
  .host_tx_wr (host_tx_wr),
  .host_rx_rd (host_rx_rd),
  .irq        (irq)
);

// File: tb/sim_fifo_pair_irq.sv
module sim_fifo_pair_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd3;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] ctl_rd, lvl_rd, sts_rd, mask_rd;
  logic        host_tx_wr = 1'b0;
  logic [7:0]  host_tx_data = '0;
  logic        host_rx_rd = 1'b0;
  logic [7:0]  host_rx_data;
  logic        eng_tx_pop = 1'b0;
  logic [7:0]  eng_tx_data;
  logic        eng_rx_push = 1'b0;
  logic [7:0]  eng_rx_data = '0;
  logic        xfer_done = 1'b0;
  logic        cs_release = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  int mtx = 0;
  int mrx = 0;
  localparam logic [31:0] TRIGS = (32'd48 << 16) | 32'd16;

  always #2 clk = ~clk;

  fifo_pair_irq u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares popped bytes with the expected order (R2)
  always @(negedge clk) begin
    if (rst_n && eng_tx_pop && txq.size() > 0) chk("R2 tx order", 32'(eng_tx_data), 32'(txq.pop_front()));
    if (rst_n && host_rx_rd && rxq.size() > 0) chk("R2 rx order", 32'(host_rx_data), 32'(rxq.pop_front()));
  end

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
    @(posedge clk); #1 cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1 cfg_we = 1'b0; cfg_sel = 2'd3;
  endtask

  task automatic host_push(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 host_tx_wr = 1'b1; host_tx_data = base + 8'(i);
      if (mtx < 64) begin txq.push_back(base + 8'(i)); mtx++; end
    end
    @(posedge clk); #1 host_tx_wr = 1'b0;
  endtask

  task automatic eng_pop(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 eng_tx_pop = 1'b1;
      if (mtx > 0) mtx--;
    end
    @(posedge clk); #1 eng_tx_pop = 1'b0;
  endtask

  task automatic eng_push(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 eng_rx_push = 1'b1; eng_rx_data = base + 8'(3 * i);
      if (mrx < 64) begin rxq.push_back(base + 8'(3 * i)); mrx++; end
    end
    @(posedge clk); #1 eng_rx_push = 1'b0;
  endtask

  task automatic host_pop(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 host_rx_rd = 1'b1;
      if (mrx > 0) mrx--;
    end
    @(posedge clk); #1 host_rx_rd = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 ctl", ctl_rd, 0);
    chk("R1 lvl", lvl_rd, 0);
    chk("R1 sts", sts_rd, 0);
    chk("R1 irq", 32'(irq), 0);
    settle();
    chk("R7 empties after reset", sts_rd, 32'h33);

    reg_wr(2'd0, TRIGS);
    settle();
    chk("R3 trig readback", ctl_rd, TRIGS);
    reg_wr(2'd2, 32'h3FFF);
    settle();
    chk("R10 clear all", sts_rd, 32'h32);

    host_push(10, 8'hA0);
    settle();
    chk("R2 tx level", 32'(lvl_rd[23:16]), 10);
    eng_pop(10);
    settle();
    chk("R2 tx drained", lvl_rd, 0);

    host_push(49, 8'h10);
    reg_wr(2'd2, 32'h10);
    settle();
    chk("R5 above watermark", 32'(sts_rd[4]), 0);
    eng_pop(1);
    settle();
    chk("R5 at watermark", 32'(sts_rd[4]), 1);

    host_push(16, 8'h60);
    settle();
    chk("R7 tx full", 32'(sts_rd[6]), 1);
    host_push(1, 8'hEE);
    settle();
    chk("R8 tx overflow flag", 32'(sts_rd[10]), 1);
    chk("R8 tx overflow discarded", 32'(lvl_rd[23:16]), 64);

    reg_wr(2'd2, 32'h40);
    @(negedge clk);
    chk("R10 level bit cleared", 32'(sts_rd[6]), 0);
    @(negedge clk);
    chk("R10 level bit reasserted", 32'(sts_rd[6]), 1);
    reg_wr(2'd2, 32'h400);
    settle();
    chk("R10 sticky cleared", 32'(sts_rd[10]), 0);

    reg_wr(2'd1, 32'h40);
    @(negedge clk);
    chk("R11 irq on", 32'(irq), 1);
    reg_wr(2'd1, 32'h400);
    @(negedge clk);
    chk("R11 irq masked", 32'(irq), 0);
    reg_wr(2'd1, 32'h0);

    eng_pop(64);
    eng_pop(1);
    settle();
    chk("R8 tx underrun", 32'(sts_rd[11]), 1);

    eng_push(15, 8'h05);
    reg_wr(2'd2, 32'h1);
    settle();
    chk("R6 below watermark", 32'(sts_rd[0]), 0);
    eng_push(1, 8'h77);
    settle();
    chk("R6 at watermark", 32'(sts_rd[0]), 1);
    chk("R2 rx level", 32'(lvl_rd[7:0]), 16);
    host_pop(16);
    host_pop(1);
    settle();
    chk("R8 rx underrun", 32'(sts_rd[9]), 1);

    eng_push(65, 8'h20);
    settle();
    chk("R8 rx overflow flag", 32'(sts_rd[8]), 1);
    chk("R7 rx full", 32'(sts_rd[2]), 1);
    chk("R8 rx overflow discarded", 32'(lvl_rd[7:0]), 64);

    host_push(5, 8'hC0);
    reg_wr(2'd0, TRIGS | 32'h8000);
    @(negedge clk);
    chk("R4 rx flush bit set", 32'(ctl_rd[15]), 1);
    rxq.delete(); mrx = 0;
    @(negedge clk);
    chk("R4 rx flush bit clear", 32'(ctl_rd[15]), 0);
    chk("R4 rx flushed, tx kept", lvl_rd, 32'h0005_0000);
    reg_wr(2'd0, TRIGS | 32'h8000_0000);
    @(negedge clk);
    chk("R4 tx flush bit set", 32'(ctl_rd[31]), 1);
    txq.delete(); mtx = 0;
    @(negedge clk);
    chk("R4 tx flushed", ctl_rd, TRIGS);
    chk("R4 tx level zero", lvl_rd, 0);

    @(posedge clk); #1 xfer_done = 1'b1;
    @(posedge clk); #1 xfer_done = 1'b0;
    @(negedge clk);
    chk("R9 done flag", 32'(sts_rd[12]), 1);
    chk("R12 done one edge", 32'(sts_rd[13]), 0);
    @(posedge clk); #1 cs_release = 1'b1;
    @(posedge clk); #1 cs_release = 1'b0;
    settle();
    chk("R9 cs flag", 32'(sts_rd[13]), 1);
    reg_wr(2'd1, 32'h2000);
    @(negedge clk);
    chk("R11 irq from cs flag", 32'(irq), 1);

    host_push(1, 8'h3C);
    @(negedge clk);
    chk("R12 level flag lags", 32'(sts_rd[5]), 1);
    finish_run();
  end
endmodule